// File: doc/BRIEF.md
# Lock-Gated ADC Sample Capture

This block takes the 8-bit words and overrange bit from a single-data-rate converter. Everything runs in the converter's own data clock. The converter presents a new word on every rising edge, and the block registers each word with a valid strobe and an overrange flag. Capture begins only after the clock-conditioning circuit reports lock. It also waits for the external reset to be released through a synchronizer. Until then, valid, data and overrange are held at zero.

The lock indicator is resynchronized through two flops in the capture domain. That synchronized lock then feeds a two-flop chain that produces the local active-low run enable, so the local reset can only be released once lock is seen as stable. Any assertion of the external reset clears lock, both chains and the capture register at once, and the full lock wait starts again. A loss of lock while running pulls the local reset low again through the same chains.

For self-contained use, the block includes a behavioural lock source, selected by a parameter. It asserts lock a set number of clock edges after reset release, with a default of 4096. The output of that source is ANDed with a lock qualifier input, so a loss of lock can be injected. With the lock source switched off, the qualifier input is the lock itself. The raw lock level is also brought out as an output, with no synchronization; a consumer in another clock domain must synchronize it.

Top module: `adc_lock_capture`

## Requirements
- R1: While `rst` is high, `smp_valid`, `smp_data`, `smp_ovr` and `lock_out` are all 0, whatever the converter inputs are.
- R2: With the lock source enabled and `lock_in` high, `lock_out` is 0 after rising edges 1 to LOCK_WAIT-1 following reset release, and 1 from rising edge LOCK_WAIT onward.
- R3: `smp_valid` is 0 after the first rising edge following reset release, and stays 0 while the lock seen by the synchronizer is low.
- R4: When the raw lock is first sampled high at rising edge k, `smp_valid` is still 0 after edge k+3 and becomes 1 after edge k+4. With the lock source this is edge LOCK_WAIT+5 after release.
- R5: While `smp_valid` is 1, `smp_data` after rising edge k equals `adc_d` as sampled at edge k. The capture is single data rate, on the rising edge only.
- R6: While `smp_valid` is 1, `smp_ovr` after rising edge k equals `adc_ovr` as sampled at edge k. It is 1 exactly for captures whose sample was flagged overrange.
- R7: While `smp_valid` is 0, `smp_data` is all zeros and `smp_ovr` is 0, even when the converter drives nonzero data and overrange.
- R8: Raising `rst` in the middle of a clock period clears `smp_valid`, `smp_data`, `smp_ovr` and `lock_out` before the next rising edge.
- R9: Every release of `rst` restarts the whole lock wait: the R2 and R4 timing applies again, counted from the new release.
- R10: If the raw lock is first sampled low at rising edge j while running, `smp_valid` stays 1 after edges j to j+3 and is 0 after edge j+4. Capture resumes under the R4 timing once lock returns.
- R11: `lock_out` is the raw lock level with no register in its path. A change of `lock_in` reaches `lock_out` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter data clock; every register is clocked on its rising edge |
| rst | input | 1 | External reset, active high, asserted asynchronously |
| adc_d | input | SAMPLE_W | Sample word from the converter |
| adc_ovr | input | 1 | Overrange bit belonging to the current sample |
| lock_in | input | 1 | Lock qualifier: ANDed with the lock source output, or the lock itself when the lock source is disabled |
| smp_data | output | SAMPLE_W | Captured sample; zero while not valid |
| smp_ovr | output | 1 | Captured overrange flag; zero while not valid |
| smp_valid | output | 1 | High for every cycle carrying a captured sample |
| lock_out | output | 1 | Raw lock level, not synchronized |

## Verification
The assertions assume that `rst` is held high for at least one full clock period, and that the converter inputs and `lock_in` do not change close to a rising edge. Under these conditions the synchronizers behave as pure delays and never resolve metastability. The stimulus changes every input on the falling edge. It raises `rst` only in the middle of the high phase, after the previous result has been compared, and lowers it on a falling edge. Lock is therefore removed and restored a whole half period away from any sampling edge.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  // Default word width of the converter interface
  localparam int unsigned SAMPLE_W_DEF  = 8;
  // Default number of data-clock edges the lock source waits after reset release
  localparam int unsigned LOCK_WAIT_DEF = 4096;
  // Default depth of each synchronizer chain
  localparam int unsigned SYNC_DEF      = 2;

endpackage

// File: rtl/cap_sync_chain.sv
module cap_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      sr <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        sr[i] <= sr[i-1];
      end
      sr[0] <= d;
    end
  end

  assign q = sr[STAGES-1];

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (clr)
    q |-> $past(d, STAGES));

endmodule

// File: rtl/cap_lock_model.sv
module cap_lock_model #(
  parameter int unsigned LOCK_WAIT = 4096
) (
  input  logic clk,
  input  logic clr,
  output logic lock
);

  localparam int unsigned CW = $clog2(LOCK_WAIT + 1);

  logic [CW-1:0] cnt;
  logic          lock_r;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      cnt    <= '0;
      lock_r <= 1'b0;
    end else if (!lock_r) begin
      if (cnt == CW'(LOCK_WAIT - 1)) begin
        lock_r <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign lock = lock_r;

  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (clr)
    lock_r |=> lock_r);

endmodule

// File: rtl/cap_sample_reg.sv
module cap_sample_reg #(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                run_n,
  input  logic [SAMPLE_W-1:0] d,
  input  logic                ovr,
  output logic [SAMPLE_W-1:0] data_q,
  output logic                ovr_q,
  output logic                valid_q
);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      data_q  <= '0;
      ovr_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (!run_n) begin
      data_q  <= '0;
      ovr_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= d;
      ovr_q   <= ovr;
      valid_q <= 1'b1;
    end
  end

  // R3
  valid_after_run_chk: assert property (@(posedge clk) disable iff (clr)
    valid_q |-> $past(run_n));

  // R7
  zero_when_idle_chk: assert property (@(posedge clk) disable iff (clr)
    !valid_q |-> (data_q == '0 && !ovr_q));

endmodule

// File: rtl/adc_lock_capture.sv
module adc_lock_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned SAMPLE_W       = SAMPLE_W_DEF,
  parameter int unsigned LOCK_WAIT      = LOCK_WAIT_DEF,
  parameter int unsigned SYNC_STAGES    = SYNC_DEF,
  parameter bit          USE_LOCK_MODEL = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] adc_d,
  input  logic                adc_ovr,
  input  logic                lock_in,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_ovr,
  output logic                smp_valid,
  output logic                lock_out
);

  logic lock_raw;
  logic lock_ok;
  logic run_n;

  // Lock source variant picked by parameter
  if (USE_LOCK_MODEL) begin : g_model
    logic model_lock;
    cap_lock_model #(.LOCK_WAIT(LOCK_WAIT)) i_lock_model (
      .clk  (clk),
      .clr  (rst),
      .lock (model_lock)
    );
    assign lock_raw = model_lock & lock_in;
  end else begin : g_external
    assign lock_raw = lock_in;
  end

  // Raw level goes out untouched; other domains must resynchronize it
  assign lock_out = lock_raw;

  // Lock resynchronizer in the data-clock domain
  cap_sync_chain #(.STAGES(SYNC_STAGES)) i_lock_sync (
    .clk (clk),
    .clr (rst),
    .d   (lock_ok_in_unused_guard(lock_raw)),
    .q   (lock_ok)
  );

  // Local reset release chain, fed by the synchronized lock
  cap_sync_chain #(.STAGES(SYNC_STAGES)) i_run_sync (
    .clk (clk),
    .clr (rst),
    .d   (lock_ok),
    .q   (run_n)
  );

  cap_sample_reg #(.SAMPLE_W(SAMPLE_W)) i_sample_reg (
    .clk     (clk),
    .clr     (rst),
    .run_n   (run_n),
    .d       (adc_d),
    .ovr     (adc_ovr),
    .data_q  (smp_data),
    .ovr_q   (smp_ovr),
    .valid_q (smp_valid)
  );

  function automatic logic lock_ok_in_unused_guard(input logic v);
    return v;
  endfunction

  // R8
  rst_clears_chk: assert property (@(posedge clk)
    rst |-> (!smp_valid && !lock_ok && !run_n && smp_data == '0));

  // R4
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(lock_ok, SYNC_STAGES + 1));

  // R10
  lock_loss_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_ok) |-> ##SYNC_STAGES !run_n);

endmodule

// File: tb/test_adc_lock_capture.sv
module test_adc_lock_capture;

  localparam int N = 16;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] adc_d = 8'hA5;
  logic         adc_ovr = 1'b1;
  logic         lock_in = 1'b1;
  logic [W-1:0] smp_data;
  logic         smp_ovr;
  logic         smp_valid;
  logic         lock_out;

  always #4 clk = ~clk;

  adc_lock_capture #(.SAMPLE_W(W), .LOCK_WAIT(N), .SYNC_STAGES(2), .USE_LOCK_MODEL(1'b1))
    i_adc_lock_capture (
      .clk       (clk),
      .rst       (rst),
      .adc_d     (adc_d),
      .adc_ovr   (adc_ovr),
      .lock_in   (lock_in),
      .smp_data  (smp_data),
      .smp_ovr   (smp_ovr),
      .smp_valid (smp_valid),
      .lock_out  (lock_out)
    );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Requirement-level timing model: edges since release and raw-lock history
  int         edges;
  logic [4:0] hist;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      edges <= 0;
      hist  <= '0;
    end else begin
      edges <= edges + 1;
      hist  <= {hist[3:0], (edges >= N) && lock_in};
    end
  end

  typedef struct {
    logic         v;
    logic [W-1:0] d;
    logic         o;
    logic         l;
  } exp_t;
  exp_t sbq[$];

  // Driver: sets inputs on the falling edge and queues the result of the next rising edge
  task automatic cycle(input logic [W-1:0] d, input logic o, input logic li);
    exp_t e;
    @(negedge clk);
    adc_d   = d;
    adc_ovr = o;
    lock_in = li;
    e.v = hist[3];
    e.d = e.v ? d : '0;
    e.o = e.v ? o : 1'b0;
    e.l = ((edges + 1) >= N) && li;
    sbq.push_back(e);
  endtask

  // Monitor: compares just after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      check(smp_valid === e.v, "R4", "valid", smp_valid, e.v);
      check(smp_data === e.d, e.v ? "R5" : "R7", "data", smp_data, e.d);
      check(smp_ovr === e.o, e.v ? "R6" : "R7", "ovr", smp_ovr, e.o);
      check(lock_out === e.l, "R2", "lock_out", lock_out, e.l);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state with busy converter inputs
    repeat (3) @(posedge clk);
    #2;
    check(smp_valid === 1'b0, "R1", "valid in reset", smp_valid, 0);
    check(smp_data === '0, "R1", "data in reset", smp_data, 0);
    check(smp_ovr === 1'b0, "R1", "ovr in reset", smp_ovr, 0);
    check(lock_out === 1'b0, "R1", "lock_out in reset", lock_out, 0);

    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check(smp_valid === 1'b0, "R3", "valid at first edge", smp_valid, 0);

    // Lock wait, then a ramp with every third sample flagged
    for (int j = 2; j <= N + 30; j++) begin
      cycle(W'(j * 7), (j % 3) == 0, 1'b1);
      if (j == N - 1 || j == N) begin
        @(posedge clk);
        #2;
        check(lock_out === (j >= N), "R2", "lock_out edge", lock_out, j >= N);
        check(smp_data === '0, "R7", "data while waiting", smp_data, 0);
      end
      if (j == N + 4 || j == N + 5) begin
        @(posedge clk);
        #2;
        check(smp_valid === (j == N + 5), "R4", "valid release", smp_valid, j == N + 5);
      end
    end

    // Alternating extremes
    for (int k = 0; k < 12; k++) begin
      cycle((k % 2) ? 8'hFF : 8'h00, (k % 2) == 0, 1'b1);
    end

    // R8: asynchronous reset in mid-cycle
    @(posedge clk);
    #2;
    rst = 1'b1;
    #1;
    check(smp_valid === 1'b0, "R8", "valid after async rst", smp_valid, 0);
    check(smp_data === '0, "R8", "data after async rst", smp_data, 0);
    check(smp_ovr === 1'b0, "R8", "ovr after async rst", smp_ovr, 0);
    check(lock_out === 1'b0, "R8", "lock_out after async rst", lock_out, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: full wait again
    @(posedge clk);
    #2;
    check(smp_valid === 1'b0, "R9", "valid at first edge again", smp_valid, 0);
    for (int j = 2; j <= N + 8; j++) begin
      cycle(W'(8'hC3 ^ j), (j % 2) == 1, 1'b1);
      if (j == N - 1 || j == N) begin
        @(posedge clk);
        #2;
        check(lock_out === (j >= N), "R9", "lock_out restart", lock_out, j >= N);
      end
      if (j == N + 4 || j == N + 5) begin
        @(posedge clk);
        #2;
        check(smp_valid === (j == N + 5), "R9", "valid restart", smp_valid, j == N + 5);
      end
    end

    // R10 and R11: lock loss while running
    for (int m = 0; m <= 5; m++) begin
      cycle(W'(8'h3C + m), 1'b0, 1'b0);
      if (m == 0) begin
        #1;
        check(lock_out === 1'b0, "R11", "lock_out follows lock_in low", lock_out, 0);
      end
      @(posedge clk);
      #2;
      check(smp_valid === (m <= 3), "R10", "valid after lock loss", smp_valid, m <= 3);
    end
    cycle(8'h11, 1'b1, 1'b1);
    #1;
    check(lock_out === 1'b1, "R11", "lock_out follows lock_in high", lock_out, 1);
    for (int k = 0; k < 10; k++) begin
      cycle(W'(8'h80 + k), (k % 4) == 0, 1'b1);
    end

    repeat (2) @(posedge clk);
    #2;
    finish_run();
  end

endmodule